// File: doc/BRIEF.md
# BCD Timekeeper with Alarm Compare

This block keeps calendar time in packed BCD, from thousandths of a second up to the month, and presents it as a bank of 32 byte-wide registers. A host reaches the registers through a 5-bit index, an 8-bit write bus, an 8-bit read bus and chip-select, read and write strobes. Time advances by one thousandth on every cycle in which the single-cycle `tick_1k` pulse is high. The pulse comes from a 1 kHz timebase outside the block.

An eight-byte alarm RAM is compared with the time on every advance. Each alarm field has a wildcard encoding. Periodic events and the alarm match set bits in a status byte that clears when read. A mask byte selects which status bits drive the active-high interrupt. A separate active-low standby interrupt reports only the alarm match. Write-only command indices reset the counters, clear the alarm RAM, or zero the seconds with a round-up of the minutes. A read-to-clear flag records that a carry left the thousandths counter.

Top module: `rtc_bcd_alarm`

## Requirements
- R1: After reset, indices 0..7 read 0x00,0x00,0x00,0x00,0x00,0x01,0x01,0x01. All other indices read 0x00, `irq` is low and `stby_irq_n` is high.
- R2: A tick advances index 0 (thousandths 0..9). When a field passes its maximum it returns to its minimum and the next field advances. The chain is index 1 hundredths 0..99, index 2 seconds 0..59, index 3 minutes 0..59, index 4 hours 0..23. An hours carry advances both index 5 (day of week 1..7) and index 6 (day of month). A carry out of index 6 advances index 7 (month 1..12). All values are BCD.
- R3: Day of month wraps to 1 after 28 in month 0x02, after 30 in months 0x04, 0x06, 0x09 and 0x11, and after 31 in every other month.
- R4: Indices 8..15 are alarm bytes for fields 0..7 and are read back as written. After each tick advance, if every field matches, status bit 7 is set. A field matches when its alarm byte equals the new time value, or when the byte has bits 7:6 both set. For the day-of-week byte (index 13) the wildcard test is bits 3:2 both set instead.
- R5: On a tick advance, status bits are set as follows: bit 6 when the hundredths units digit wraps, bit 5 when seconds are carried into, bit 4 when minutes are carried into, bit 3 when hours are carried into, bit 2 at midnight, bit 1 at midnight when day of week goes from 7 to 1, and bit 0 when the month advances. Index 17 is the read/write mask with the same layout.
- R6: Index 16 returns the status byte, and a read of it clears the byte. A bit set by an event in the same cycle as the read survives the clear. `irq` is high while any status bit is set whose mask bit is set.
- R7: Writing 0xFF to index 18 returns indices 0..7 to their reset values. Writing 0xFF to index 19 zeroes indices 8..15. Any other value written to either index has no effect.
- R8: Index 20 reads 0x01 once a tick has carried out of the thousandths, and 0x00 otherwise. A read of it clears the flag, unless a new carry occurs in the same cycle.
- R9: Any write to index 21 zeroes indices 0..2. If seconds were 0x40 or more, the minutes advance by one, with carries into hours and days. This sets no status bit.
- R10: Bit 0 of index 22 is a read/write enable. `stby_irq_n` is low while that enable is set and status bit 7 is set.
- R11: Indices 23..31 read 0x00 and ignore writes. Indices 18, 19 and 21 read 0x00.
- R12: In a cycle where a tick coincides with a write to indices 0..7, or with a command at index 18 or 21, the whole tick is dropped. The written value is stored as given, and no event fires.
- R13: `rdata` shows the addressed register in the same cycle that `cs` and `rd` are high, and reads 0x00 when no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1k | input | 1 | One-cycle pulse per thousandth of a second |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe (with cs) |
| wr | input | 1 | Write strobe (with cs) |
| addr | input | 5 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when idle |
| irq | output | 1 | Active-high masked interrupt |
| stby_irq_n | output | 1 | Active-low alarm-only standby interrupt |

## Verification
Two pairs of actions can fall in the same cycle. In the first pair, a tick arrives together with a host write to a time field or a counter command. In the second, a tick raises an event in the cycle where the host reads the status byte or the carry flag. The bench provokes both pairs on purpose, with directed cycles, and again through a long run that places ticks and bus accesses at random. A behavioural model settles each pair by its rule: the write wins and the tick is lost, and a fresh event survives the read-clear. The model's expected interrupt levels and read data are compared with the design on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W  = 5;
    localparam int BYTE_W  = 8;
    localparam int NFIELD  = 8;
    localparam int NSRC    = 8;

    localparam int IDX_MILLI = 0;
    localparam int IDX_CENTI = 1;
    localparam int IDX_SEC   = 2;
    localparam int IDX_MIN   = 3;
    localparam int IDX_HOUR  = 4;
    localparam int IDX_WDAY  = 5;
    localparam int IDX_MDAY  = 6;
    localparam int IDX_MONTH = 7;

    typedef logic [BYTE_W-1:0] bcd8_t;

    localparam logic [ADDR_W-1:0] A_TIME0  = 5'd0;
    localparam logic [ADDR_W-1:0] A_ALARM0 = 5'd8;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'd16;
    localparam logic [ADDR_W-1:0] A_MASK   = 5'd17;
    localparam logic [ADDR_W-1:0] A_CLRT   = 5'd18;
    localparam logic [ADDR_W-1:0] A_CLRA   = 5'd19;
    localparam logic [ADDR_W-1:0] A_ROLL   = 5'd20;
    localparam logic [ADDR_W-1:0] A_ROUND  = 5'd21;
    localparam logic [ADDR_W-1:0] A_STBY   = 5'd22;

    // Add one to a two-digit BCD value without range checking.
    function automatic bcd8_t bcd_inc(input bcd8_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic bcd8_t field_floor(input int f);
        return (f >= IDX_WDAY) ? 8'h01 : 8'h00;
    endfunction

    function automatic bcd8_t field_ceiling(input int f);
        case (f)
            IDX_MILLI: return 8'h09;
            IDX_CENTI: return 8'h99;
            IDX_SEC:   return 8'h59;
            IDX_MIN:   return 8'h59;
            IDX_HOUR:  return 8'h23;
            IDX_WDAY:  return 8'h07;
            IDX_MDAY:  return 8'h31;
            default:   return 8'h12;
        endcase
    endfunction

    // Field whose wrap feeds field f (both day fields hang off hours).
    function automatic int carry_src(input int f);
        return (f == IDX_MDAY) ? IDX_HOUR : f - 1;
    endfunction

    function automatic bcd8_t days_in(input bcd8_t mon);
        case (mon)
            8'h02:                      return 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
#(
    parameter int NF = NFIELD,
    localparam int IW = $clog2(NF)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  bcd8_t                wr_data,
    input  logic                 clr_time,
    input  logic                 roundup,
    output logic [NF-1:0][7:0]   cur,
    output logic [NF-1:0][7:0]   nxt,
    output logic [NSRC-2:0]      evt,
    output logic                 carry_ms
);

    logic [NF-1:0] inc;
    logic [NF-1:0] at_max;
    logic          round_carry;

    assign round_carry = roundup & (cur[IDX_SEC] >= 8'h40);

    for (genvar i = 0; i < NF; i++) begin : g_fld
        bcd8_t ceil_v;
        if (i == IDX_MDAY) begin : g_var
            assign ceil_v = days_in(cur[IDX_MONTH]);
        end else begin : g_fix
            assign ceil_v = field_ceiling(i);
        end
        assign at_max[i] = (cur[i] == ceil_v);

        if (i == 0) begin : g_first
            assign inc[i] = go;
        end else if (i == IDX_MIN) begin : g_min
            assign inc[i] = (inc[i-1] & at_max[i-1]) | round_carry;
        end else begin : g_rest
            assign inc[i] = inc[carry_src(i)] & at_max[carry_src(i)];
        end

        assign nxt[i] = inc[i] ? (at_max[i] ? field_floor(i) : bcd_inc(cur[i]))
                               : cur[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) cur[i] <= field_floor(i);
        end else begin
            for (int i = 0; i < NF; i++) begin
                if (clr_time)
                    cur[i] <= field_floor(i);
                else if (roundup && i <= IDX_SEC)
                    cur[i] <= 8'h00;
                else if (wr_en && wr_idx == IW'(i))
                    cur[i] <= wr_data;
                else
                    cur[i] <= nxt[i];
            end
        end
    end

    // Periodic sources, only from a real tick (never from the round-up).
    assign evt[6]   = go & at_max[IDX_MILLI] & (cur[IDX_CENTI][3:0] == 4'h9);
    assign evt[5]   = inc[IDX_SEC];
    assign evt[4]   = go & inc[IDX_MIN];
    assign evt[3]   = go & inc[IDX_HOUR];
    assign evt[2]   = go & inc[IDX_WDAY];
    assign evt[1]   = go & inc[IDX_WDAY] & at_max[IDX_WDAY];
    assign evt[0]   = go & inc[IDX_MONTH];
    assign carry_ms = inc[IDX_CENTI];

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_pkg::*;
#(
    parameter int NF = NFIELD
) (
    input  logic [NF-1:0][7:0] tval,
    input  logic [NF-1:0][7:0] alarm,
    output logic               hit
);

    logic [NF-1:0] fmatch;

    for (genvar i = 0; i < NF; i++) begin : g_cmp
        logic wild;
        if (i == IDX_WDAY) begin : g_wday
            assign wild = (alarm[i][3:2] == 2'b11);
        end else begin : g_std
            assign wild = (alarm[i][7:6] == 2'b11);
        end
        assign fmatch[i] = wild | (alarm[i] == tval[i]);
    end

    assign hit = &fmatch;

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_pkg::*;
#(
    parameter int SRC = NSRC
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SRC-1:0] ev,
    input  logic           carry,
    input  logic           clr_status,
    input  logic           clr_roll,
    input  logic [SRC-1:0] mask,
    input  logic           stby_en,
    output logic [SRC-1:0] status,
    output logic           roll,
    output logic           irq,
    output logic           stby_irq_n
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            roll   <= 1'b0;
        end else begin
            status <= (clr_status ? '0 : status) | ev;
            roll   <= (clr_roll & ~roll) ? 1'b0 : roll;
            if (clr_roll) roll <= carry;
            else if (carry) roll <= 1'b1;
        end
    end

    assign irq        = |(status & mask);
    assign stby_irq_n = ~(stby_en & status[SRC-1]);

endmodule

// File: rtl/rtc_bcd_alarm.sv
module rtc_bcd_alarm
    import rtc_pkg::*;
#(
    parameter int NF = NFIELD,
    localparam int IW = $clog2(NF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1k,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq,
    output logic              stby_irq_n
);

    logic                rd_hit, wr_hit;
    logic                wr_time, wr_alarm, cmd_clr_time, cmd_clr_alarm, cmd_round;
    logic                go;
    logic [NF-1:0][7:0]  t_cur, t_nxt;
    logic [NF-1:0][7:0]  alarm_q;
    logic [NSRC-1:0]     mask_q, status, ev;
    logic [NSRC-2:0]     evt;
    logic                stby_q, roll, carry_ms, alarm_hit;

    assign rd_hit        = cs & rd;
    assign wr_hit        = cs & wr & ~rd;
    assign wr_time       = wr_hit & (addr < A_TIME0 + ADDR_W'(NF));
    assign wr_alarm      = wr_hit & (addr >= A_ALARM0) & (addr < A_ALARM0 + ADDR_W'(NF));
    assign cmd_clr_time  = wr_hit & (addr == A_CLRT) & (wdata == 8'hFF);
    assign cmd_clr_alarm = wr_hit & (addr == A_CLRA) & (wdata == 8'hFF);
    assign cmd_round     = wr_hit & (addr == A_ROUND);
    assign go            = tick_1k & ~(wr_time | cmd_clr_time | cmd_round);

    rtc_time_chain #(.NF(NF)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .wr_en    (wr_time),
        .wr_idx   (addr[IW-1:0]),
        .wr_data  (wdata),
        .clr_time (cmd_clr_time),
        .roundup  (cmd_round),
        .cur      (t_cur),
        .nxt      (t_nxt),
        .evt      (evt),
        .carry_ms (carry_ms)
    );

    rtc_alarm_cmp #(.NF(NF)) u_cmp (
        .tval  (t_nxt),
        .alarm (alarm_q),
        .hit   (alarm_hit)
    );

    assign ev = {go & alarm_hit, evt};

    rtc_irq_ctrl #(.SRC(NSRC)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .carry      (carry_ms),
        .clr_status (rd_hit & (addr == A_STAT)),
        .clr_roll   (rd_hit & (addr == A_ROLL)),
        .mask       (mask_q),
        .stby_en    (stby_q),
        .status     (status),
        .roll       (roll),
        .irq        (irq),
        .stby_irq_n (stby_irq_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= '0;
            mask_q  <= '0;
            stby_q  <= 1'b0;
        end else begin
            if (cmd_clr_alarm)
                alarm_q <= '0;
            else if (wr_alarm)
                alarm_q[addr[IW-1:0]] <= wdata;
            if (wr_hit && addr == A_MASK) mask_q <= wdata;
            if (wr_hit && addr == A_STBY) stby_q <= wdata[0];
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (rd_hit) begin
            if (addr < A_TIME0 + ADDR_W'(NF))
                rdata = t_cur[addr[IW-1:0]];
            else if (addr < A_ALARM0 + ADDR_W'(NF))
                rdata = alarm_q[addr[IW-1:0]];
            else if (addr == A_STAT)
                rdata = status;
            else if (addr == A_MASK)
                rdata = mask_q;
            else if (addr == A_ROLL)
                rdata = {7'd0, roll};
            else if (addr == A_STBY)
                rdata = {7'd0, stby_q};
        end
    end

endmodule

// File: rtl/rtc_bcd_alarm_sva.sv
module rtc_bcd_alarm_sva #(
    parameter int NF = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_1k,
    input logic               cs,
    input logic               rd,
    input logic               wr,
    input logic [4:0]         addr,
    input logic [7:0]         wdata,
    input logic [7:0]         rdata,
    input logic               irq,
    input logic               stby_irq_n,
    input logic [NF-1:0][7:0] t_cur
);

    // R6: a status read with no tick leaves nothing pending
    a_r6_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr == 5'd16 && !tick_1k) |=> !irq);

    // R10: the same read releases the standby interrupt
    a_r10_read_releases_stby: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr == 5'd16 && !tick_1k) |=> stby_irq_n);

    // R12: a time write lands exactly as given
    a_r12_time_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !rd && addr < 5'd8) |=> (t_cur[$past(addr[2:0])] == $past(wdata)));

    // R9: the round-up command zeroes the low three fields
    a_r9_roundup_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !rd && addr == 5'd21)
        |=> (t_cur[0] == 8'h00 && t_cur[1] == 8'h00 && t_cur[2] == 8'h00));

    // R2: an undisturbed tick always moves the thousandths
    a_r2_tick_moves_milli: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1k && !(cs && wr)) |=> (t_cur[0] != $past(t_cur[0])));

    // R11: unused indices read zero
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr >= 5'd23) |-> (rdata == 8'h00));

    // R13: idle bus reads zero
    a_r13_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |-> (rdata == 8'h00));

endmodule

bind rtc_bcd_alarm rtc_bcd_alarm_sva #(.NF(NF)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1k    (tick_1k),
    .cs         (cs),
    .rd         (rd),
    .wr         (wr),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .irq        (irq),
    .stby_irq_n (stby_irq_n),
    .t_cur      (t_cur)
);

// File: tb/tb_rtc_bcd_alarm.sv
module tb_rtc_bcd_alarm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1k = 1'b0, cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, stby_irq_n;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    rtc_bcd_alarm dut (
        .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .cs(cs), .rd(rd), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .stby_irq_n(stby_irq_n)
    );

    // ---------------- behavioural reference (decimal time) ----------------
    int m_t[8];              // ms, centi, sec, min, hour, wday, mday, month
    logic [7:0] m_alarm[8];
    logic [7:0] m_stat, m_mask;
    bit m_roll, m_stby;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int month_len(input int mon);
        if (mon == 2) return 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_t = '{0, 0, 0, 0, 0, 1, 1, 1};
        for (int i = 0; i < 8; i++) m_alarm[i] = 8'h00;
        m_stat = 0; m_mask = 0; m_roll = 0; m_stby = 0;
    endtask

    // advance day fields; returns 1 when the month moved
    function automatic bit next_day();
        m_t[5] = (m_t[5] == 7) ? 1 : m_t[5] + 1;
        if (m_t[6] == month_len(m_t[7])) begin
            m_t[6] = 1;
            m_t[7] = (m_t[7] == 12) ? 1 : m_t[7] + 1;
            return 1'b1;
        end
        m_t[6] = m_t[6] + 1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] mread(input int a);
        if (a < 8)   return (a >= 5 || a < 5) ? to_bcd(m_t[a]) : 8'h00;
        if (a < 16)  return m_alarm[a-8];
        if (a == 16) return m_stat;
        if (a == 17) return m_mask;
        if (a == 20) return {7'd0, m_roll};
        if (a == 22) return {7'd0, m_stby};
        return 8'h00;
    endfunction

    task automatic model_step(input bit t, c, r, w, input int a, input logic [7:0] d);
        bit rh, wh, drop, carry, hit;
        logic [7:0] ev;
        rh = c && r;
        wh = c && w && !r;
        drop = wh && (a < 8 || (a == 18 && d == 8'hFF) || a == 21);
        ev = 0; carry = 0;
        if (t && !drop) begin
            m_t[0]++;
            if (m_t[0] == 10) begin
                m_t[0] = 0; carry = 1;
                if (m_t[1] % 10 == 9) ev[6] = 1;
                m_t[1]++;
                if (m_t[1] == 100) begin
                    m_t[1] = 0; ev[5] = 1; m_t[2]++;
                    if (m_t[2] == 60) begin
                        m_t[2] = 0; ev[4] = 1; m_t[3]++;
                        if (m_t[3] == 60) begin
                            m_t[3] = 0; ev[3] = 1; m_t[4]++;
                            if (m_t[4] == 24) begin
                                m_t[4] = 0; ev[2] = 1;
                                if (m_t[5] == 7) ev[1] = 1;
                                if (next_day()) ev[0] = 1;
                            end
                        end
                    end
                end
            end
            hit = 1;
            for (int i = 0; i < 8; i++) begin
                bit wild;
                wild = (i == 5) ? (m_alarm[i][3:2] == 2'b11) : (m_alarm[i][7:6] == 2'b11);
                if (!wild && m_alarm[i] != to_bcd(m_t[i])) hit = 0;
            end
            ev[7] = hit;
        end
        if (wh) begin
            if (a < 8) m_t[a] = from_bcd(d);
            else if (a < 16) m_alarm[a-8] = d;
            else if (a == 17) m_mask = d;
            else if (a == 18 && d == 8'hFF) m_t = '{0, 0, 0, 0, 0, 1, 1, 1};
            else if (a == 19 && d == 8'hFF) for (int i = 0; i < 8; i++) m_alarm[i] = 0;
            else if (a == 21) begin
                if (m_t[2] >= 40) begin
                    m_t[3]++;
                    if (m_t[3] == 60) begin
                        m_t[3] = 0; m_t[4]++;
                        if (m_t[4] == 24) begin
                            m_t[4] = 0;
                            void'(next_day());
                        end
                    end
                end
                m_t[0] = 0; m_t[1] = 0; m_t[2] = 0;
            end
            else if (a == 22) m_stby = d[0];
        end
        m_stat = ((rh && a == 16) ? 8'h00 : m_stat) | ev;
        m_roll = ((rh && a == 20) ? 1'b0 : m_roll) | carry;
    endtask

    // ---------------- checking ----------------
    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string req_of(input int a);
        if (a < 8)   return "R2";
        if (a < 16)  return "R4";
        if (a == 16) return "R6";
        if (a == 17) return "R5";
        if (a == 20) return "R8";
        if (a == 22) return "R10";
        return "R11";
    endfunction

    task automatic step(input bit t, c, r, w, input int a, input logic [7:0] d,
                        input string tag);
        @(negedge clk);
        chk({7'd0, irq}, {7'd0, (m_stat & m_mask) != 0}, "R6 irq");
        chk({7'd0, stby_irq_n}, {7'd0, !(m_stby && m_stat[7])}, "R10 stby_irq_n");
        tick_1k = t; cs = c; rd = r; wr = w; addr = a[4:0]; wdata = d;
        #1;
        if (c && r) chk(rdata, mread(a), (tag == "") ? req_of(a) : tag);
        else        chk(rdata, 8'h00, "R13");
        @(posedge clk);
        model_step(t, c, r, w, a, d);
    endtask

    task automatic wreg(input int a, input logic [7:0] d);
        step(0, 1, 0, 1, a, d, "");
    endtask

    task automatic rreg(input int a, input string tag);
        step(0, 1, 1, 0, a, 8'h00, tag);
    endtask

    task automatic tick_once();
        step(1, 0, 0, 0, 0, 8'h00, "");
    endtask

    task automatic set_time(input int ms, ce, s, mi, h, wd, md, mo);
        wreg(0, to_bcd(ms)); wreg(1, to_bcd(ce)); wreg(2, to_bcd(s));
        wreg(3, to_bcd(mi)); wreg(4, to_bcd(h)); wreg(5, to_bcd(wd));
        wreg(6, to_bcd(md)); wreg(7, to_bcd(mo));
    endtask

    task automatic read_time(input string tag);
        for (int i = 0; i < 8; i++) rreg(i, tag);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #2_000_000;
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 32; i++) rreg(i, "R1");

        // R5 all periodic sources at once, R3 February wrap
        wreg(17, 8'hFF);
        set_time(9, 99, 59, 59, 23, 7, 28, 2);
        tick_once();
        read_time("R3");
        rreg(16, "R5");
        rreg(16, "R6");

        // R3 thirty-day month, thirty-one-day month, year end
        set_time(9, 99, 59, 59, 23, 2, 30, 4);
        tick_once(); read_time("R3");
        set_time(9, 99, 59, 59, 23, 2, 30, 1);
        tick_once(); read_time("R3");
        set_time(9, 99, 59, 59, 23, 3, 31, 12);
        tick_once(); read_time("R3");
        rreg(16, "R5");

        // R8 rollover flag and read-clear with a coinciding carry
        set_time(8, 0, 0, 0, 0, 1, 1, 1);
        tick_once(); rreg(20, "R8");
        tick_once(); rreg(20, "R8"); rreg(20, "R8");
        wreg(0, to_bcd(9));
        step(1, 1, 1, 0, 20, 8'h00, "R8");
        rreg(20, "R8");

        // R6 status read in the same cycle as a new tenth event
        wreg(17, 8'h40);
        set_time(9, 9, 0, 0, 0, 1, 1, 1);
        step(1, 1, 1, 0, 16, 8'h00, "R6");
        rreg(16, "R6");

        // R4 wildcard alarm and exact alarm, R10 standby output
        wreg(22, 8'h01); rreg(22, "R10");
        for (int i = 0; i < 8; i++) wreg(8 + i, (i == 5) ? 8'h0C : 8'hC0);
        for (int i = 0; i < 8; i++) rreg(8 + i, "R4");
        wreg(17, 8'h80);
        tick_once(); tick_once();
        rreg(16, "R4");
        set_time(3, 0, 0, 0, 0, 1, 1, 1);
        for (int i = 0; i < 8; i++) wreg(8 + i, to_bcd(m_t[i]));
        wreg(8, to_bcd(5));
        tick_once(); rreg(16, "R4");
        tick_once(); rreg(16, "R4");

        // R7 commands with other values, then 0xFF
        wreg(19, 8'h12); for (int i = 0; i < 8; i++) rreg(8 + i, "R7");
        wreg(18, 8'h34); read_time("R7");
        wreg(19, 8'hFF); for (int i = 0; i < 8; i++) rreg(8 + i, "R7");
        set_time(5, 12, 33, 44, 5, 6, 7, 8);
        step(1, 1, 0, 1, 18, 8'hFF, "R7");
        read_time("R7");

        // R9 round-up with and without minute advance
        set_time(4, 56, 45, 59, 23, 7, 31, 12);
        wreg(17, 8'hFF);
        rreg(16, "R9");
        step(1, 1, 0, 1, 21, 8'h00, "R9");
        read_time("R9"); rreg(16, "R9");
        set_time(4, 56, 39, 10, 5, 2, 3, 4);
        wreg(21, 8'h00); read_time("R9");

        // R11 unused and command indices
        for (int i = 23; i < 32; i++) wreg(i, 8'hA5);
        for (int i = 23; i < 32; i++) rreg(i, "R11");
        rreg(18, "R11"); rreg(19, "R11"); rreg(21, "R11");

        // R12 tick against a time write, and against a non-time write
        set_time(2, 0, 0, 0, 0, 1, 1, 1);
        step(1, 1, 0, 1, 0, 8'h05, "R12");
        rreg(0, "R12");
        step(1, 1, 0, 1, 17, 8'h00, "R12");
        rreg(0, "R12");

        // R2 / R13 long mixed run
        wreg(17, 8'hFF);
        for (int n = 0; n < 60000; n++) begin
            int op, a;
            bit t;
            t  = ($urandom % 3) == 0;
            op = $urandom % 100;
            a  = $urandom % 32;
            if (op < 30) begin
                step(t, 1, 1, 0, a, 8'h00, "");
            end else if (op < 33) begin
                int f;
                f = $urandom % 8;
                wreg(8 + f, ($urandom % 2) ? ((f == 5) ? 8'h0C : 8'hC0) : to_bcd($urandom % 10));
            end else if (op == 33) begin
                int f, v;
                f = $urandom % 8;
                case (f)
                    0: v = $urandom % 10;
                    1: v = $urandom % 100;
                    2, 3: v = $urandom % 60;
                    4: v = $urandom % 24;
                    5: v = 1 + $urandom % 7;
                    6: v = 1 + $urandom % 28;
                    default: v = 1 + $urandom % 12;
                endcase
                step(t, 1, 0, 1, f, to_bcd(v), "R12");
            end else if (op == 34) begin
                wreg(22, 8'($urandom % 2));
            end else begin
                step(t, 0, 0, 0, 0, 8'h00, "");
            end
        end
        read_time("R2");

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule